// File: doc/BRIEF.md
# ADC serial control register controller

This block is the digital control side of a multi-channel sampling converter. A host writes a 10-bit control word serially, most significant bit first. Each write opens with a falling edge on an active-low frame strobe, and each bit arrives on a cycle where a bit-valid qualifier is high. All inputs are synchronous to the system clock. The word is committed on the cycle that delivers its tenth bit. A frame that closes early leaves no trace.

Two such devices can share one serial bus. Each device has a strapped address pin and compares one bit of every complete word against it. A matching word is stored. A word that does not match is dropped whole, and the device also gives up the right to drive readback data. Only the device that accepted the most recent word enables its serial output during a read frame.

The stored word sets three things:
- the power mode, including automatic power-down at the end of a conversion;
- the analog input pairing;
- the reference selection.

A start bit in the word requests a conversion. The block issues a one-clock start pulse a fixed number of clocks after the commit. The request stays pending until the converter core reports that the conversion is done.

Top module: `adc_ctrl_port`

## Requirements
- R1: After reset `fullPowerDown`=1, `partialPowerDown`=0, `refPowerDown`=0, `posSel`=0, `negSel`=0, `negIsGnd`=1, and `busOwner`, `sdoOe`, `convStart` and `convPending` are all 0.
- R2: After a falling edge of `frameN`, each cycle with `bitValid`=1 while `frameN`=0 shifts in `bitIn`, most significant bit first. The word is committed on the clock edge that captures the tenth bit. Further bits in the same frame, and bits offered while `frameN`=1, are ignored.
- R3: If `frameN` rises before ten bits have arrived, the word is discarded and every output keeps its value.
- R4: Bit 8 of the word is compared with `addrPin`. On a mismatch, the power, channel, reference and conversion outputs are left unchanged and no start pulse follows.
- R5: A matched commit sets `busOwner` and a mismatched commit clears it. `sdoOe` equals `busOwner` while `rdFrameN`=0 and is 0 otherwise.
- R6: Bits 7:6 hold the power code.
  - 00: `fullPowerDown`=1 at once.
  - 11: the device stays powered up, whatever happens at the end of a conversion.
  - 01: the device is awake after the write. `partialPowerDown` rises on the edge after `convDone`.
  - 10: the device is awake after the write. `fullPowerDown` rises on the edge after `convDone`.
  - For 01 and 10, the automatic power-down state ends when a word is accepted or when `convStart` fires. `fullPowerDown` and `partialPowerDown` are never both 1.
- R7: Bit 5 (ground/input-4 select), bit 4 (pair mode) and bits 3:2 (channel) set the input mux.
  - Bit 4=0, bit 5=0: `posSel`=channel, `negIsGnd`=1, `negSel`=0.
  - Bit 4=0, bit 5=1: `posSel`=channel, `negSel`=3, `negIsGnd`=0.
  - Bit 4=1: `posSel`=channel, `negSel`=channel XOR 1, `negIsGnd`=0. This gives the pairs 1/2 and 3/4 in either polarity.
- R8: `refPowerDown` follows bit 0 of the last accepted word.
- R9: An accepted word with bit 1 = 1 sets `convPending`. `convStart` is then high for exactly one cycle, START_DLY clock edges after the commit edge. `convPending` clears on the edge after `convDone`. An accepted word with bit 1 = 0 clears `convPending` and cancels any start pulse still waiting.
- R10: When a commit and `convDone` fall in the same cycle, the new word wins. `convPending` takes the new start bit, and the automatic power-down state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameN | input | 1 | Active-low write frame strobe |
| bitValid | input | 1 | Qualifies `bitIn` for one cycle |
| bitIn | input | 1 | Serial control data |
| addrPin | input | 1 | Strapped device address |
| rdFrameN | input | 1 | Active-low readback frame |
| convDone | input | 1 | End-of-conversion pulse from the core |
| sdoOe | output | 1 | Serial output drive enable |
| busOwner | output | 1 | This device accepted the last complete word |
| convStart | output | 1 | One-cycle conversion launch |
| convPending | output | 1 | Start bit held until conversion end |
| fullPowerDown | output | 1 | Full power-down request |
| partialPowerDown | output | 1 | Partial power-down request |
| refPowerDown | output | 1 | Internal reference off |
| posSel | output | 2 | Positive input index (0..3) |
| negSel | output | 2 | Negative input index when not ground |
| negIsGnd | output | 1 | Negative input is analog ground |

## Verification
Two events can land in the same clock edge: the commit of a new word and the `convDone` from the previous conversion. The end-of-conversion logic would then apply an automatic power-down and clear the pending start, while the write would load a new start bit and wake the device. The bench sets this up by raising `convDone` in the same cycle as the tenth bit of a start-requesting word, with the power code at partial power-down. It then expects `convPending` high and `partialPowerDown` low, followed by a start pulse exactly START_DLY edges later. A sweep over every word value and both address straps checks all the other decodes against values computed in the bench.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int WORD_W     = 10;
  localparam int ADDR_BIT   = 8;
  localparam int PD_HI      = 7;
  localparam int PD_LO      = 6;
  localparam int IN4_BIT    = 5;
  localparam int DIFF_BIT   = 4;
  localparam int CH_HI      = 3;
  localparam int CH_LO      = 2;
  localparam int START_BIT  = 1;
  localparam int EXTREF_BIT = 0;

  typedef enum logic [1:0] {
    PD_FULL_NOW    = 2'b00,
    PD_PARTIAL_EOC = 2'b01,
    PD_FULL_EOC    = 2'b10,
    PD_AWAKE       = 2'b11
  } pdCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic commit;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [1:0] pdCode;
    logic       in4Ref;
    logic       diffMode;
    logic [1:0] chSel;
    logic       extRef;
  } ctrlCfg_t;
endpackage

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
#(
  parameter int START_DLY = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        bitValid,
  input  logic        convDone,
  input  logic        addrOk,
  input  logic        newStart,
  input  logic [1:0]  curPd,
  output ctrlStrobe_t strobe,
  output logic        convStart,
  output logic        convPending,
  output logic        autoDown
);
  localparam int CNT_W  = $clog2(START_DLY + 1);
  localparam int BCNT_W = $clog2(WORD_W + 1);

  logic              frameQ;
  logic              frameFall;
  logic              accept;
  logic              eocModes;
  logic [BCNT_W-1:0] bitCnt;
  logic [BCNT_W-1:0] effCnt;
  logic [CNT_W-1:0]  dlyCnt;
  logic              dlyLast;

  always_comb begin
    frameFall      = frameQ & ~frameN;
    effCnt         = frameFall ? '0 : bitCnt;
    strobe.shiftEn = bitValid & ~frameN & (effCnt < BCNT_W'(WORD_W));
    strobe.commit  = strobe.shiftEn & (effCnt == BCNT_W'(WORD_W - 1));
    accept         = strobe.commit & addrOk;
    dlyLast        = (dlyCnt == CNT_W'(1));
    eocModes       = (curPd == PD_PARTIAL_EOC) || (curPd == PD_FULL_EOC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ      <= 1'b1;
      bitCnt      <= BCNT_W'(WORD_W);
      dlyCnt      <= '0;
      convStart   <= 1'b0;
      convPending <= 1'b0;
      autoDown    <= 1'b0;
    end else begin
      frameQ    <= frameN;
      bitCnt    <= effCnt + BCNT_W'(strobe.shiftEn);
      convStart <= ~accept & dlyLast;

      if (accept)
        dlyCnt <= newStart ? CNT_W'(START_DLY) : '0;
      else if (dlyCnt != '0)
        dlyCnt <= dlyCnt - CNT_W'(1);

      if (accept)
        convPending <= newStart;
      else if (convDone)
        convPending <= 1'b0;

      if (accept || dlyLast)
        autoDown <= 1'b0;
      else if (convDone && eocModes)
        autoDown <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_ctrl_dp.sv
module adc_ctrl_dp
  import adc_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitIn,
  input  logic        addrPin,
  input  logic        rdFrameN,
  input  ctrlStrobe_t strobe,
  input  logic        autoDown,
  output logic        addrOk,
  output logic        newStart,
  output logic [1:0]  curPd,
  output logic        busOwner,
  output logic        sdoOe,
  output logic        fullPowerDown,
  output logic        partialPowerDown,
  output logic        refPowerDown,
  output logic [1:0]  posSel,
  output logic [1:0]  negSel,
  output logic        negIsGnd
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  ctrlCfg_t          cfgQ;

  always_comb begin
    nextWord = {shiftReg[WORD_W-2:0], bitIn};
    addrOk   = (nextWord[ADDR_BIT] == addrPin);
    newStart = nextWord[START_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cfgQ     <= '0;
      busOwner <= 1'b0;
    end else begin
      if (strobe.shiftEn)
        shiftReg <= nextWord;
      if (strobe.commit) begin
        busOwner <= addrOk;
        if (addrOk) begin
          cfgQ.pdCode   <= nextWord[PD_HI:PD_LO];
          cfgQ.in4Ref   <= nextWord[IN4_BIT];
          cfgQ.diffMode <= nextWord[DIFF_BIT];
          cfgQ.chSel    <= nextWord[CH_HI:CH_LO];
          cfgQ.extRef   <= nextWord[EXTREF_BIT];
        end
      end
    end
  end

  always_comb begin
    curPd            = cfgQ.pdCode;
    fullPowerDown    = (cfgQ.pdCode == PD_FULL_NOW) ||
                       ((cfgQ.pdCode == PD_FULL_EOC) && autoDown);
    partialPowerDown = (cfgQ.pdCode == PD_PARTIAL_EOC) && autoDown;
    refPowerDown     = cfgQ.extRef;
    sdoOe            = busOwner & ~rdFrameN;
    posSel           = cfgQ.chSel;
    if (cfgQ.diffMode) begin
      negSel   = {cfgQ.chSel[1], ~cfgQ.chSel[0]};
      negIsGnd = 1'b0;
    end else if (cfgQ.in4Ref) begin
      negSel   = 2'd3;
      negIsGnd = 1'b0;
    end else begin
      negSel   = 2'd0;
      negIsGnd = 1'b1;
    end
  end
endmodule

// File: rtl/adc_ctrl_port.sv
module adc_ctrl_port
  import adc_ctrl_pkg::*;
#(
  parameter int START_DLY = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       addrPin,
  input  logic       rdFrameN,
  input  logic       convDone,
  output logic       sdoOe,
  output logic       busOwner,
  output logic       convStart,
  output logic       convPending,
  output logic       fullPowerDown,
  output logic       partialPowerDown,
  output logic       refPowerDown,
  output logic [1:0] posSel,
  output logic [1:0] negSel,
  output logic       negIsGnd
);
  ctrlStrobe_t strobe;
  logic        addrOk;
  logic        newStart;
  logic        autoDown;
  logic [1:0]  curPd;

  adc_ctrl_seq #(.START_DLY(START_DLY)) u_seq (
    .clk(clk), .rstN(rstN), .frameN(frameN), .bitValid(bitValid),
    .convDone(convDone), .addrOk(addrOk), .newStart(newStart),
    .curPd(curPd), .strobe(strobe), .convStart(convStart),
    .convPending(convPending), .autoDown(autoDown)
  );

  adc_ctrl_dp u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .addrPin(addrPin),
    .rdFrameN(rdFrameN), .strobe(strobe), .autoDown(autoDown),
    .addrOk(addrOk), .newStart(newStart), .curPd(curPd),
    .busOwner(busOwner), .sdoOe(sdoOe), .fullPowerDown(fullPowerDown),
    .partialPowerDown(partialPowerDown), .refPowerDown(refPowerDown),
    .posSel(posSel), .negSel(negSel), .negIsGnd(negIsGnd)
  );
endmodule

// File: rtl/adc_ctrl_port_chk.sv
module adc_ctrl_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameN,
  input logic       bitValid,
  input logic       convDone,
  input logic       busOwner,
  input logic       convStart,
  input logic       convPending,
  input logic       fullPowerDown,
  input logic       partialPowerDown,
  input logic       refPowerDown,
  input logic [1:0] posSel,
  input logic [1:0] negSel,
  input logic       negIsGnd
);
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_power_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(fullPowerDown && partialPowerDown));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameN) |-> ($stable(posSel) && $stable(negSel) &&
                       $stable(negIsGnd) && $stable(refPowerDown)));

  p_owner_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwner) |-> $past(bitValid && !frameN));

  p_partial_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(partialPowerDown) |-> $past(convDone));

  p_pending_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convPending) |-> $past(convDone || bitValid));
endmodule

bind adc_ctrl_port adc_ctrl_port_chk u_chk (
  .clk(clk), .rstN(rstN), .frameN(frameN), .bitValid(bitValid),
  .convDone(convDone), .busOwner(busOwner), .convStart(convStart),
  .convPending(convPending), .fullPowerDown(fullPowerDown),
  .partialPowerDown(partialPowerDown), .refPowerDown(refPowerDown),
  .posSel(posSel), .negSel(negSel), .negIsGnd(negIsGnd)
);

// File: tb/test_adc_ctrl_port.sv
module test_adc_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, bitValid = 1'b0, bitIn = 1'b0, addrPin = 1'b0;
  logic rdFrameN = 1'b1, convDone = 1'b0;
  logic sdoOe, busOwner, convStart, convPending;
  logic fullPowerDown, partialPowerDown, refPowerDown, negIsGnd;
  logic [1:0] posSel, negSel;

  int nChecks = 0;
  int nFail   = 0;

  // bench model of the configuration
  logic [1:0] mPd = 2'b00;
  logic mIn4 = 0, mDiff = 0, mExt = 0, mAuto = 0, mOwner = 0, mPend = 0;
  logic [1:0] mCh = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctrl_port #(.START_DLY(DLY)) i_adc_ctrl_port (
    .clk(clk), .rstN(rstN), .frameN(frameN), .bitValid(bitValid),
    .bitIn(bitIn), .addrPin(addrPin), .rdFrameN(rdFrameN),
    .convDone(convDone), .sdoOe(sdoOe), .busOwner(busOwner),
    .convStart(convStart), .convPending(convPending),
    .fullPowerDown(fullPowerDown), .partialPowerDown(partialPowerDown),
    .refPowerDown(refPowerDown), .posSel(posSel), .negSel(negSel),
    .negIsGnd(negIsGnd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] expMux();
    logic [1:0] n;
    logic g;
    if (mDiff) begin n = mCh ^ 2'b01; g = 1'b0; end
    else if (mIn4) begin n = 2'd3; g = 1'b0; end
    else begin n = 2'd0; g = 1'b1; end
    return {mCh, n, g};
  endfunction

  function automatic logic [1:0] expPwr();
    return {(mPd == 2'b00) || (mPd == 2'b10 && mAuto), (mPd == 2'b01) && mAuto};
  endfunction

  task automatic checkAll(input string ctx);
    chk({ctx, " R6 power"}, {14'd0, fullPowerDown, partialPowerDown}, {14'd0, expPwr()});
    chk({ctx, " R7 mux"}, {11'd0, posSel, negSel, negIsGnd}, {11'd0, expMux()});
    chk({ctx, " R8 ref"}, {15'd0, refPowerDown}, {15'd0, mExt});
    chk({ctx, " R5 owner"}, {15'd0, busOwner}, {15'd0, mOwner});
    chk({ctx, " R9 pending"}, {15'd0, convPending}, {15'd0, mPend});
  endtask

  task automatic sendBits(input logic [15:0] v, input int n, input bit doneAtLast);
    @(negedge clk); frameN = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bitValid = 1'b1; bitIn = v[i];
      convDone = doneAtLast && (i == 0);
    end
    @(negedge clk);
    bitValid = 1'b0; convDone = 1'b0; frameN = 1'b1;
  endtask

  // applies the model for an accepted word
  task automatic modelAccept(input logic [9:0] w);
    mPd = w[7:6]; mIn4 = w[5]; mDiff = w[4]; mCh = w[3:2];
    mExt = w[0]; mAuto = 1'b0; mPend = w[1]; mOwner = 1'b1;
  endtask

  // watches DLY+2 edges, expects a single pulse at edge DLY when expPulse
  task automatic watchStart(input string ctx, input bit expPulse);
    int hits = 0, first = 0;
    for (int k = 1; k <= DLY + 2; k++) begin
      @(negedge clk);
      if (convStart) begin hits++; if (first == 0) first = k; end
    end
    chk({ctx, " R9 pulse count"}, 16'(hits), expPulse ? 16'd1 : 16'd0);
    if (expPulse) chk({ctx, " R9 pulse edge"}, 16'(first), 16'(DLY));
  endtask

  task automatic pulseDone();
    @(negedge clk); convDone = 1'b1;
    @(negedge clk); convDone = 1'b0;
    mPend = 1'b0;
    if (mPd == 2'b01 || mPd == 2'b10) mAuto = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [9:0] w;
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs",
        {6'd0, fullPowerDown, partialPowerDown, refPowerDown, posSel, negSel, negIsGnd, sdoOe, busOwner},
        {6'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0});
    chk("R1 reset conv", {14'd0, convStart, convPending}, 16'd0);

    // R4 R6 R7 R8 R9 exhaustive sweep over word value and address strap
    for (int i = 0; i < 2048; i++) begin
      logic match;
      w = i[9:0];
      addrPin = i[10];
      match = (w[8] == addrPin);
      sendBits({6'd0, w}, 10, 1'b0);
      if (match) modelAccept(w); else mOwner = 1'b0;
      checkAll(match ? "sweep match R2" : "sweep mismatch R4");
      watchStart("sweep", match && w[1]);
      pulseDone();
      checkAll("after done R6");
      if (i[5:0] == 6'd0) begin
        rdFrameN = 1'b0; #1;
        chk("R5 sdoOe in read", {15'd0, sdoOe}, {15'd0, mOwner});
        rdFrameN = 1'b1; #1;
        chk("R5 sdoOe idle", {15'd0, sdoOe}, 16'd0);
      end
    end

    // set a known config: pd awake, diff mode, ch 2, ext ref
    addrPin = 1'b1;
    w = 10'b0111011001;
    sendBits({6'd0, w}, 10, 1'b0); modelAccept(w);
    checkAll("setup R7");
    snap = {7'd0, fullPowerDown, partialPowerDown, refPowerDown, posSel, negSel, negIsGnd, busOwner};

    // R3 partial frame of a different word
    sendBits({9'd0, 7'b1000110}, 7, 1'b0);
    chk("R3 partial frame",
        {7'd0, fullPowerDown, partialPowerDown, refPowerDown, posSel, negSel, negIsGnd, busOwner}, snap);
    // next full frame still works after the partial one
    w = 10'b0100000100;
    sendBits({6'd0, w}, 10, 1'b0); modelAccept(w);
    checkAll("after partial R3");

    // R2 bits while frame high are ignored
    for (int i = 9; i >= 0; i--) begin
      @(negedge clk); bitValid = 1'b1; bitIn = i[0];
    end
    @(negedge clk); bitValid = 1'b0;
    checkAll("frame high R2");

    // R2 extra bits after the tenth ignored
    w = 10'b0110110000;
    sendBits({4'd0, w, 2'b11}, 12, 1'b0); modelAccept(w);
    checkAll("extra bits R2");

    // R10 commit coincides with convDone, pd partial-at-eoc
    w = 10'b0101000000;
    sendBits({6'd0, w}, 10, 1'b0); modelAccept(w);
    pulseDone();
    chk("R6 partial after done", {15'd0, partialPowerDown}, 16'd1);
    w = 10'b0101000010;
    sendBits({6'd0, w}, 10, 1'b1); modelAccept(w);
    chk("R10 pending wins", {15'd0, convPending}, 16'd1);
    chk("R10 awake wins", {14'd0, fullPowerDown, partialPowerDown}, 16'd0);
    watchStart("R10", 1'b1);
    pulseDone();
    checkAll("R10 end");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule